// File: doc/BRIEF.md
# Double-Buffered Pipe Packet Buffer

This block holds the packet data of one USB pipe in two banks that alternate between a CPU/DMA word port and a serial interface engine (SIE) port. One side fills a bank while the other side drains the other bank. The direction input picks the roles. In send direction the CPU fills and the SIE drains. In receive direction the SIE fills and the CPU drains. A bank passes from the filling side to the draining side only when it is full, or when the filling side marks an end of packet. A packet with no bytes (zero-length packet, ZLP) is handed over in the same way.

Software sees one ready flag for the CPU-side bank, whose meaning depends on direction, and a separate occupancy flag for the SIE side that only has meaning in send direction. A four-bit control register issues the clears: two one-shot clear bits (CPU side, SIE side), an auto-clear mode that frees a received bank on the read of its last byte, and a level bit that keeps the SIE-side bank clear for as long as it is set. A build parameter selects one bank instead of two.

Top module: `pipe_dbuf_buffer`

## Requirements
- R1: After reset no bank holds data, every count reads 0, the control register reads 0 and `sie_busy_o` is 0. `cpu_rdy_o` is 1 in send direction (`dir_i`=1) and 0 in receive direction (`dir_i`=0).
- R2: In receive direction `cpu_rdy_o` stays 0 until the SIE ends a packet with `sie_eop_i`. It is then 1, `cpu_cnt_o` gives the byte count, and `cpu_rd_i` steps through the bytes on `cpu_rdata_o` in arrival order. A second packet waits in the other bank.
- R3: A received ZLP sets `cpu_rdy_o` to 1 with `cpu_cnt_o` = 0. CPU reads have no effect on it, and auto-clear does not release it either. Only the CPU-side clear does.
- R4: In send direction `cpu_rdy_o` is 1 while the CPU-side bank is free. It is 0 when no bank is free, and CPU writes made while it is 0 are ignored.
- R5: A bank is handed over when the write of its BANK_BYTES-th byte is accepted, or when the filling side commits (`cpu_commit_i` in send, `sie_eop_i` in receive). A commit of an empty bank hands over a ZLP.
- R6: `sie_busy_o` is 1 only in send direction, only in the two-bank build, and only while at least one handed-over bank still waits for the SIE. It is 0 in every other case.
- R7: Control bit 0 is a one-shot CPU-side clear. It reads back 1 for exactly one cycle after it is written and 0 afterwards. One cycle after the write, the CPU-side bank is emptied: in send direction the partly written bank is discarded, and in receive direction the ready packet is released.
- R8: Control bit 1 is a one-shot SIE-side clear with the same timing as bit 0. In send direction it drops the oldest waiting bank. In receive direction it discards a partly received packet, and `sie_len_o` returns to 0.
- R9: While control bit 2 (auto-clear) is 1 in receive direction, the CPU read of the last byte of a packet releases the bank in that same cycle.
- R10: While control bit 3 is 1, the SIE-side bank is cleared in every cycle. A bank handed over in send direction during that time is dropped one cycle later.
- R11: When a clear and a hand-over of the same bank fall in the same cycle, the clear wins: the bank stays unhanded with count 0. Whenever a clear leaves no data in any bank, both bank pointers return to bank 0.
- R12: In send direction `sie_rdata_o` gives the bytes of the oldest waiting bank in write order as `sie_rd_i` steps through them. `sie_done_i` releases that bank, and the banks are used alternately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dir_i | input | 1 | 1 = send (CPU fills), 0 = receive (SIE fills) |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 4 | Control write data: bit0 CPU clear, bit1 SIE clear, bit2 auto-clear, bit3 repeated SIE clear |
| ctl_rdata_o | output | 4 | Control register readback |
| cpu_rdy_o | output | 1 | CPU-side bank status (meaning per direction) |
| sie_busy_o | output | 1 | SIE-side occupancy in send direction |
| cpu_cnt_o | output | $clog2(BANK_BYTES+1) | Byte count of the CPU-side bank |
| cpu_wr_i | input | 1 | CPU byte write |
| cpu_wdata_i | input | 8 | CPU write data |
| cpu_commit_i | input | 1 | CPU commits a short packet or ZLP |
| cpu_rd_i | input | 1 | CPU byte read |
| cpu_rdata_o | output | 8 | Byte at the CPU read position |
| sie_rdy_o | output | 1 | SIE may push (receive) or pop (send) |
| sie_len_o | output | $clog2(BANK_BYTES+1) | Byte count of the SIE-side bank |
| sie_wr_i | input | 1 | SIE byte push |
| sie_wdata_i | input | 8 | SIE push data |
| sie_eop_i | input | 1 | SIE end of received packet |
| sie_rd_i | input | 1 | SIE byte pop |
| sie_done_i | input | 1 | SIE finished sending the waiting bank |
| sie_rdata_o | output | 8 | Byte at the SIE read position |

## Verification
The bench builds two copies that share all stimulus. Both use four-byte banks, so the hand-over of a full bank takes only four writes. One copy has two banks and the other has one. The short banks reach the full-bank hand-over, the case where both banks wait, and blocked writes within a few cycles. The single-bank copy shows when `sie_busy_o` must stay 0, and that the ready flag drops after one packet where the two-bank copy keeps accepting data.

// File: rtl/pipe_buf_pkg.sv
package pipe_buf_pkg;
  localparam int CTL_W       = 4;
  localparam int CTL_CPU_CLR = 0;
  localparam int CTL_SIE_CLR = 1;
  localparam int CTL_AUTO    = 2;
  localparam int CTL_REP     = 3;
endpackage

// File: rtl/pipe_ctl_regs.sv
module pipe_ctl_regs
  import pipe_buf_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CTL_W-1:0] wdata_i,
  output logic             cpu_clr_o,
  output logic             sie_clr_o,
  output logic             auto_o,
  output logic             rep_o,
  output logic [CTL_W-1:0] rdata_o
);
  logic cpu_clr_q, sie_clr_q, auto_q, rep_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cpu_clr_q <= 1'b0;
      sie_clr_q <= 1'b0;
      auto_q    <= 1'b0;
      rep_q     <= 1'b0;
    end else begin
      // one-shot bits drop on their own
      cpu_clr_q <= we_i & wdata_i[CTL_CPU_CLR];
      sie_clr_q <= we_i & wdata_i[CTL_SIE_CLR];
      if (we_i) begin
        auto_q <= wdata_i[CTL_AUTO];
        rep_q  <= wdata_i[CTL_REP];
      end
    end
  end

  assign cpu_clr_o = cpu_clr_q;
  assign sie_clr_o = sie_clr_q;
  assign auto_o    = auto_q;
  assign rep_o     = rep_q;

  always_comb begin
    rdata_o              = '0;
    rdata_o[CTL_CPU_CLR] = cpu_clr_q;
    rdata_o[CTL_SIE_CLR] = sie_clr_q;
    rdata_o[CTL_AUTO]    = auto_q;
    rdata_o[CTL_REP]     = rep_q;
  end
endmodule

// File: rtl/pipe_bank_store.sv
module pipe_bank_store #(
  parameter int NUM_BANKS  = 2,
  parameter int BANK_BYTES = 64,
  parameter int DATA_W     = 8,
  localparam int IDX_W     = $clog2(BANK_BYTES),
  localparam int PTR_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk_i,
  input  logic              wr_en_i,
  input  logic [PTR_W-1:0]  wr_bank_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [PTR_W-1:0]  rd_bank_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] bank_rd [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [DATA_W-1:0] mem_q [BANK_BYTES];
    always_ff @(posedge clk_i) begin
      if (wr_en_i && (wr_bank_i == PTR_W'(b))) mem_q[wr_idx_i] <= wr_data_i;
    end
    assign bank_rd[b] = mem_q[rd_idx_i];
  end

  assign rd_data_o = bank_rd[rd_bank_i];
endmodule

// File: rtl/pipe_bank_ctrl.sv
module pipe_bank_ctrl #(
  parameter int NUM_BANKS  = 2,
  parameter int BANK_BYTES = 64,
  localparam int CNT_W     = $clog2(BANK_BYTES + 1),
  localparam int IDX_W     = $clog2(BANK_BYTES),
  localparam int PTR_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             prod_wr_i,
  input  logic             prod_commit_i,
  input  logic             prod_clr_i,
  input  logic             cons_rd_i,
  input  logic             cons_done_i,
  input  logic             cons_clr_i,
  input  logic             auto_en_i,
  output logic             prod_free_o,
  output logic             cons_vld_o,
  output logic             any_vld_o,
  output logic [CNT_W-1:0] wcnt_o,
  output logic [CNT_W-1:0] rcnt_o,
  output logic             wr_en_o,
  output logic [PTR_W-1:0] wbank_o,
  output logic [IDX_W-1:0] widx_o,
  output logic [PTR_W-1:0] rbank_o,
  output logic [IDX_W-1:0] ridx_o
);
  logic [NUM_BANKS-1:0] valid_q, valid_n;
  logic [CNT_W-1:0]     cnt_q  [NUM_BANKS];
  logic [CNT_W-1:0]     cnt_n  [NUM_BANKS];
  logic [CNT_W-1:0]     ridx_q [NUM_BANKS];
  logic [CNT_W-1:0]     ridx_n [NUM_BANKS];
  logic [PTR_W-1:0]     wp_q, wp_n, rp_q, rp_n;

  logic prod_free, pclr, wr_acc, handover, rd_acc, auto_rel, rel;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    ptr_inc = (p == PTR_W'(NUM_BANKS - 1)) ? '0 : p + 1'b1;
  endfunction

  assign prod_free = ~valid_q[wp_q];
  // a producer clear only touches a bank still being filled
  assign pclr      = prod_clr_i & prod_free;
  assign wr_acc    = prod_wr_i & prod_free & ~pclr;
  assign handover  = prod_free & ~pclr &
                     (prod_commit_i | (wr_acc & (cnt_q[wp_q] == CNT_W'(BANK_BYTES - 1))));
  assign rd_acc    = cons_rd_i & valid_q[rp_q] & (ridx_q[rp_q] < cnt_q[rp_q]);
  assign auto_rel  = auto_en_i & rd_acc & ((ridx_q[rp_q] + 1'b1) == cnt_q[rp_q]);
  assign rel       = valid_q[rp_q] & (cons_done_i | cons_clr_i | auto_rel);

  always_comb begin
    valid_n = valid_q;
    cnt_n   = cnt_q;
    ridx_n  = ridx_q;
    wp_n    = wp_q;
    rp_n    = rp_q;
    if (rd_acc) ridx_n[rp_q] = ridx_q[rp_q] + 1'b1;
    if (rel) begin
      valid_n[rp_q] = 1'b0;
      cnt_n[rp_q]   = '0;
      ridx_n[rp_q]  = '0;
      rp_n          = ptr_inc(rp_q);
    end
    if (pclr) begin
      cnt_n[wp_q] = '0;
    end else begin
      if (wr_acc) cnt_n[wp_q] = cnt_q[wp_q] + 1'b1;
      if (handover) begin
        valid_n[wp_q] = 1'b1;
        wp_n          = ptr_inc(wp_q);
      end
    end
    // a clear that leaves nothing stored re-homes both pointers
    if ((prod_clr_i || cons_clr_i) && (valid_n == '0) && (cnt_n[wp_n] == '0)) begin
      wp_n = '0;
      rp_n = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      wp_q    <= '0;
      rp_q    <= '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
        cnt_q[b]  <= '0;
        ridx_q[b] <= '0;
      end
    end else begin
      valid_q <= valid_n;
      wp_q    <= wp_n;
      rp_q    <= rp_n;
      for (int b = 0; b < NUM_BANKS; b++) begin
        cnt_q[b]  <= cnt_n[b];
        ridx_q[b] <= ridx_n[b];
      end
    end
  end

  assign prod_free_o = prod_free;
  assign cons_vld_o  = valid_q[rp_q];
  assign any_vld_o   = |valid_q;
  assign wcnt_o      = cnt_q[wp_q];
  assign rcnt_o      = cnt_q[rp_q];
  assign wr_en_o     = wr_acc;
  assign wbank_o     = wp_q;
  assign widx_o      = cnt_q[wp_q][IDX_W-1:0];
  assign rbank_o     = rp_q;
  assign ridx_o      = ridx_q[rp_q][IDX_W-1:0];
endmodule

// File: rtl/pipe_dbuf_buffer.sv
module pipe_dbuf_buffer
  import pipe_buf_pkg::*;
#(
  parameter int NUM_BANKS  = 2,
  parameter int BANK_BYTES = 64,
  parameter int DATA_W     = 8
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               dir_i,
  input  logic                               ctl_we_i,
  input  logic [CTL_W-1:0]                   ctl_wdata_i,
  output logic [CTL_W-1:0]                   ctl_rdata_o,
  output logic                               cpu_rdy_o,
  output logic                               sie_busy_o,
  output logic [$clog2(BANK_BYTES+1)-1:0]    cpu_cnt_o,
  input  logic                               cpu_wr_i,
  input  logic [DATA_W-1:0]                  cpu_wdata_i,
  input  logic                               cpu_commit_i,
  input  logic                               cpu_rd_i,
  output logic [DATA_W-1:0]                  cpu_rdata_o,
  output logic                               sie_rdy_o,
  output logic [$clog2(BANK_BYTES+1)-1:0]    sie_len_o,
  input  logic                               sie_wr_i,
  input  logic [DATA_W-1:0]                  sie_wdata_i,
  input  logic                               sie_eop_i,
  input  logic                               sie_rd_i,
  input  logic                               sie_done_i,
  output logic [DATA_W-1:0]                  sie_rdata_o
);
  localparam int CNT_W = $clog2(BANK_BYTES + 1);
  localparam int IDX_W = $clog2(BANK_BYTES);
  localparam int PTR_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  logic cpu_clr_q, sie_clr_q, auto_q, rep_q, sie_side_clr;
  logic prod_wr, prod_commit, prod_clr, cons_rd, cons_done, cons_clr;
  logic prod_free, cons_vld, any_vld, wr_en;
  logic [DATA_W-1:0] prod_data, rd_data;
  logic [CNT_W-1:0]  wcnt, rcnt;
  logic [PTR_W-1:0]  wbank, rbank;
  logic [IDX_W-1:0]  widx, ridx;

  pipe_ctl_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (ctl_we_i),
    .wdata_i   (ctl_wdata_i),
    .cpu_clr_o (cpu_clr_q),
    .sie_clr_o (sie_clr_q),
    .auto_o    (auto_q),
    .rep_o     (rep_q),
    .rdata_o   (ctl_rdata_o)
  );

  assign sie_side_clr = sie_clr_q | rep_q;

  // role mapping: send = CPU fills / SIE drains, receive = the reverse
  assign prod_wr     = dir_i ? cpu_wr_i     : sie_wr_i;
  assign prod_data   = dir_i ? cpu_wdata_i  : sie_wdata_i;
  assign prod_commit = dir_i ? cpu_commit_i : sie_eop_i;
  assign prod_clr    = dir_i ? cpu_clr_q    : sie_side_clr;
  assign cons_rd     = dir_i ? sie_rd_i     : cpu_rd_i;
  assign cons_done   = dir_i & sie_done_i;
  assign cons_clr    = dir_i ? sie_side_clr : cpu_clr_q;

  pipe_bank_ctrl #(
    .NUM_BANKS  (NUM_BANKS),
    .BANK_BYTES (BANK_BYTES)
  ) u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .prod_wr_i     (prod_wr),
    .prod_commit_i (prod_commit),
    .prod_clr_i    (prod_clr),
    .cons_rd_i     (cons_rd),
    .cons_done_i   (cons_done),
    .cons_clr_i    (cons_clr),
    .auto_en_i     (auto_q & ~dir_i),
    .prod_free_o   (prod_free),
    .cons_vld_o    (cons_vld),
    .any_vld_o     (any_vld),
    .wcnt_o        (wcnt),
    .rcnt_o        (rcnt),
    .wr_en_o       (wr_en),
    .wbank_o       (wbank),
    .widx_o        (widx),
    .rbank_o       (rbank),
    .ridx_o        (ridx)
  );

  pipe_bank_store #(
    .NUM_BANKS  (NUM_BANKS),
    .BANK_BYTES (BANK_BYTES),
    .DATA_W     (DATA_W)
  ) u_store (
    .clk_i     (clk_i),
    .wr_en_i   (wr_en),
    .wr_bank_i (wbank),
    .wr_idx_i  (widx),
    .wr_data_i (prod_data),
    .rd_bank_i (rbank),
    .rd_idx_i  (ridx),
    .rd_data_o (rd_data)
  );

  assign cpu_rdy_o   = dir_i ? prod_free : cons_vld;
  assign sie_rdy_o   = dir_i ? cons_vld  : prod_free;
  assign cpu_cnt_o   = dir_i ? wcnt : rcnt;
  assign sie_len_o   = dir_i ? rcnt : wcnt;
  assign cpu_rdata_o = rd_data;
  assign sie_rdata_o = rd_data;

  if (NUM_BANKS > 1) begin : g_dbl
    assign sie_busy_o = dir_i & any_vld;
  end else begin : g_sgl
    assign sie_busy_o = 1'b0;
  end
endmodule

// File: rtl/pipe_dbuf_chk.sv
module pipe_dbuf_chk
  import pipe_buf_pkg::*;
#(
  parameter int NUM_BANKS  = 2,
  parameter int BANK_BYTES = 64,
  localparam int CNT_W     = $clog2(BANK_BYTES + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             dir_i,
  input logic             ctl_we_i,
  input logic [CTL_W-1:0] ctl_wdata_i,
  input logic [CTL_W-1:0] ctl_rdata_o,
  input logic             cpu_rdy_o,
  input logic             sie_busy_o,
  input logic [CNT_W-1:0] cpu_cnt_o,
  input logic             cpu_wr_i,
  input logic             sie_done_i,
  input logic             cpu_clr_q,
  input logic             sie_side_clr
);
  // R7
  clr_oneshot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_rdata_o[CTL_CPU_CLR] && !(ctl_we_i && ctl_wdata_i[CTL_CPU_CLR]))
      |=> !ctl_rdata_o[CTL_CPU_CLR]);

  // R4
  blocked_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_i && !cpu_rdy_o && cpu_wr_i && !sie_done_i && !sie_side_clr && !cpu_clr_q)
      |=> $stable(cpu_cnt_o));

  // R3
  zlp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dir_i && cpu_rdy_o && (cpu_cnt_o == '0) && !cpu_clr_q) |=> cpu_rdy_o);

  // R5
  full_handover_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((NUM_BANKS > 1) && dir_i && cpu_wr_i && cpu_rdy_o && !cpu_clr_q &&
     (cpu_cnt_o == CNT_W'(BANK_BYTES - 1))) |=> sie_busy_o);

  // R11
  clr_beats_handover_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_i && cpu_clr_q && cpu_rdy_o) |=> (cpu_rdy_o && (cpu_cnt_o == '0)));
endmodule

bind pipe_dbuf_buffer pipe_dbuf_chk #(
  .NUM_BANKS  (NUM_BANKS),
  .BANK_BYTES (BANK_BYTES)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .dir_i        (dir_i),
  .ctl_we_i     (ctl_we_i),
  .ctl_wdata_i  (ctl_wdata_i),
  .ctl_rdata_o  (ctl_rdata_o),
  .cpu_rdy_o    (cpu_rdy_o),
  .sie_busy_o   (sie_busy_o),
  .cpu_cnt_o    (cpu_cnt_o),
  .cpu_wr_i     (cpu_wr_i),
  .sie_done_i   (sie_done_i),
  .cpu_clr_q    (cpu_clr_q),
  .sie_side_clr (sie_side_clr)
);

// File: tb/pipe_dbuf_buffer_tb_top.sv
`timescale 1ns/1ps
module pipe_dbuf_buffer_tb_top;
  localparam int BB    = 4;
  localparam int CNT_W = $clog2(BB + 1);

  localparam int OP_NOP  = 0;
  localparam int OP_CWR  = 1;
  localparam int OP_CMT  = 2;
  localparam int OP_SPOP = 3;
  localparam int OP_SDON = 4;
  localparam int OP_CTL  = 5;
  localparam int OP_SWR  = 6;
  localparam int OP_SEOP = 7;
  localparam int OP_CRD  = 8;

  typedef struct packed {
    logic [3:0] op;
    logic [7:0] arg;
    logic       rdy;
    logic       busy;
    logic [6:0] cnt;
    logic [7:0] dat;
  } vec_t;

  // send direction walk: op, arg, expected rdy/busy/cpu_cnt after, expected sie_rdata before pop
  localparam int NV = 24;
  localparam vec_t VEC [NV] = '{
    '{4'd1, 8'hA1, 1'b1, 1'b0, 7'd1, 8'h00},
    '{4'd1, 8'hA2, 1'b1, 1'b0, 7'd2, 8'h00},
    '{4'd2, 8'h00, 1'b1, 1'b1, 7'd0, 8'h00},
    '{4'd1, 8'hB1, 1'b1, 1'b1, 7'd1, 8'h00},
    '{4'd1, 8'hB2, 1'b1, 1'b1, 7'd2, 8'h00},
    '{4'd1, 8'hB3, 1'b1, 1'b1, 7'd3, 8'h00},
    '{4'd1, 8'hB4, 1'b0, 1'b1, 7'd2, 8'h00},
    '{4'd1, 8'hC0, 1'b0, 1'b1, 7'd2, 8'h00},
    '{4'd3, 8'h00, 1'b0, 1'b1, 7'd2, 8'hA1},
    '{4'd3, 8'h00, 1'b0, 1'b1, 7'd2, 8'hA2},
    '{4'd4, 8'h00, 1'b1, 1'b1, 7'd0, 8'h00},
    '{4'd3, 8'h00, 1'b1, 1'b1, 7'd0, 8'hB1},
    '{4'd5, 8'h02, 1'b1, 1'b1, 7'd0, 8'h00},
    '{4'd0, 8'h00, 1'b1, 1'b0, 7'd0, 8'h00},
    '{4'd1, 8'hD1, 1'b1, 1'b0, 7'd1, 8'h00},
    '{4'd5, 8'h01, 1'b1, 1'b0, 7'd1, 8'h00},
    '{4'd0, 8'h00, 1'b1, 1'b0, 7'd0, 8'h00},
    '{4'd2, 8'h00, 1'b1, 1'b1, 7'd0, 8'h00},
    '{4'd5, 8'h08, 1'b1, 1'b1, 7'd0, 8'h00},
    '{4'd0, 8'h00, 1'b1, 1'b0, 7'd0, 8'h00},
    '{4'd1, 8'hE1, 1'b1, 1'b0, 7'd1, 8'h00},
    '{4'd2, 8'h00, 1'b1, 1'b1, 7'd0, 8'h00},
    '{4'd0, 8'h00, 1'b1, 1'b0, 7'd0, 8'h00},
    '{4'd5, 8'h00, 1'b1, 1'b0, 7'd0, 8'h00}
  };

  logic clk, rst_n, dir;
  logic ctl_we, cpu_wr, cpu_commit, cpu_rd, sie_wr, sie_eop, sie_rd, sie_done;
  logic [3:0] ctl_wdata;
  logic [7:0] cpu_wdata, sie_wdata;

  logic [3:0]       d_ctl, s_ctl;
  logic             d_rdy, d_busy, d_srdy, s_rdy, s_busy, s_srdy;
  logic [CNT_W-1:0] d_cnt, d_len, s_cnt, s_len;
  logic [7:0]       d_crd, d_srd, s_crd, s_srd;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  pipe_dbuf_buffer #(.NUM_BANKS(2), .BANK_BYTES(BB)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .dir_i(dir),
    .ctl_we_i(ctl_we), .ctl_wdata_i(ctl_wdata), .ctl_rdata_o(d_ctl),
    .cpu_rdy_o(d_rdy), .sie_busy_o(d_busy), .cpu_cnt_o(d_cnt),
    .cpu_wr_i(cpu_wr), .cpu_wdata_i(cpu_wdata), .cpu_commit_i(cpu_commit),
    .cpu_rd_i(cpu_rd), .cpu_rdata_o(d_crd),
    .sie_rdy_o(d_srdy), .sie_len_o(d_len),
    .sie_wr_i(sie_wr), .sie_wdata_i(sie_wdata), .sie_eop_i(sie_eop),
    .sie_rd_i(sie_rd), .sie_done_i(sie_done), .sie_rdata_o(d_srd)
  );

  pipe_dbuf_buffer #(.NUM_BANKS(1), .BANK_BYTES(BB)) sgl_i (
    .clk_i(clk), .rst_ni(rst_n), .dir_i(dir),
    .ctl_we_i(ctl_we), .ctl_wdata_i(ctl_wdata), .ctl_rdata_o(s_ctl),
    .cpu_rdy_o(s_rdy), .sie_busy_o(s_busy), .cpu_cnt_o(s_cnt),
    .cpu_wr_i(cpu_wr), .cpu_wdata_i(cpu_wdata), .cpu_commit_i(cpu_commit),
    .cpu_rd_i(cpu_rd), .cpu_rdata_o(s_crd),
    .sie_rdy_o(s_srdy), .sie_len_o(s_len),
    .sie_wr_i(sie_wr), .sie_wdata_i(sie_wdata), .sie_eop_i(sie_eop),
    .sie_rd_i(sie_rd), .sie_done_i(sie_done), .sie_rdata_o(s_srd)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle();
    ctl_we = 0; ctl_wdata = '0; cpu_wr = 0; cpu_wdata = '0; cpu_commit = 0;
    cpu_rd = 0; sie_wr = 0; sie_wdata = '0; sie_eop = 0; sie_rd = 0; sie_done = 0;
  endtask

  // one-cycle operation; returns at the negedge after the active edge
  task automatic op(input int code, input logic [7:0] arg);
    @(negedge clk);
    case (code)
      OP_CWR:  begin cpu_wr = 1; cpu_wdata = arg; end
      OP_CMT:  cpu_commit = 1;
      OP_SPOP: sie_rd = 1;
      OP_SDON: sie_done = 1;
      OP_CTL:  begin ctl_we = 1; ctl_wdata = arg[3:0]; end
      OP_SWR:  begin sie_wr = 1; sie_wdata = arg; end
      OP_SEOP: sie_eop = 1;
      OP_CRD:  cpu_rd = 1;
      default: ;
    endcase
    @(negedge clk);
    idle();
  endtask

  task automatic do_reset(input logic d);
    @(negedge clk);
    rst_n = 0;
    dir = d;
    idle();
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; dir = 1; idle();
    do_reset(1'b1);
    // R1 send-direction reset state
    check("R1 rdy send", d_rdy, 1);
    check("R1 busy", d_busy, 0);
    check("R1 cnt", d_cnt, 0);
    check("R1 ctl", d_ctl, 0);

    // table walk, send direction (R4 R5 R6 R7 R8 R10 R12)
    for (int i = 0; i < NV; i++) begin
      if (VEC[i].op == OP_SPOP) check("R12 sie data", d_srd, VEC[i].dat);
      op(VEC[i].op, VEC[i].arg);
      check($sformatf("R4/R5 rdy v%0d", i), d_rdy, VEC[i].rdy);
      check($sformatf("R6 busy v%0d", i), d_busy, VEC[i].busy);
      check($sformatf("R5 cnt v%0d", i), d_cnt, VEC[i].cnt);
    end

    // R11 clear and commit of the same bank in one cycle
    op(OP_CWR, 8'hF1);
    @(negedge clk); ctl_we = 1; ctl_wdata = 4'h1;
    @(negedge clk); idle(); cpu_commit = 1;
    check("R7 readback one cycle", d_ctl[0], 1);
    @(negedge clk); idle();
    check("R11 rdy", d_rdy, 1);
    check("R11 busy", d_busy, 0);
    check("R11 cnt", d_cnt, 0);
    check("R7 readback cleared", d_ctl[0], 0);

    // single-bank copy against the two-bank copy
    do_reset(1'b1);
    check("R1 single rdy", s_rdy, 1);
    op(OP_CWR, 8'h5A);
    op(OP_CMT, 8'h00);
    check("R4 double rdy", d_rdy, 1);
    check("R6 double busy", d_busy, 1);
    check("R4 single rdy", s_rdy, 0);
    check("R6 single busy", s_busy, 0);
    check("R12 single data", s_srd, 8'h5A);
    op(OP_SDON, 8'h00);
    check("R12 single released", s_rdy, 1);

    // receive direction
    do_reset(1'b0);
    check("R1 rdy recv", d_rdy, 0);
    op(OP_SWR, 8'h11);
    op(OP_SWR, 8'h22);
    check("R2 not ready before eop", d_rdy, 0);
    op(OP_SEOP, 8'h00);
    check("R2 ready", d_rdy, 1);
    check("R2 count", d_cnt, 2);
    check("R2 first byte", d_crd, 8'h11);
    op(OP_CRD, 8'h00);
    check("R2 second byte", d_crd, 8'h22);
    op(OP_CRD, 8'h00);
    check("R9 no auto, still ready", d_rdy, 1);
    op(OP_CTL, 8'h01);
    op(OP_NOP, 8'h00);
    check("R7 rx release", d_rdy, 0);
    op(OP_CTL, 8'h04);
    check("R9 auto bit", d_ctl, 4);
    op(OP_SWR, 8'h33);
    op(OP_SEOP, 8'h00);
    check("R9 ready", d_rdy, 1);
    op(OP_CRD, 8'h00);
    check("R9 auto release", d_rdy, 0);
    op(OP_SEOP, 8'h00);
    check("R3 zlp ready", d_rdy, 1);
    check("R3 zlp count", d_cnt, 0);
    op(OP_CRD, 8'h00);
    check("R3 read ignored", d_rdy, 1);
    op(OP_CTL, 8'h05);
    op(OP_NOP, 8'h00);
    check("R3 cleared", d_rdy, 0);
    check("R6 recv busy", d_busy, 0);
    op(OP_SWR, 8'h44);
    check("R8 partial len", d_len, 1);
    op(OP_CTL, 8'h06);
    op(OP_NOP, 8'h00);
    check("R8 partial dropped", d_len, 0);
    check("R8 nothing ready", d_rdy, 0);
    op(OP_SWR, 8'h55);
    op(OP_SEOP, 8'h00);
    op(OP_SWR, 8'h66);
    op(OP_SEOP, 8'h00);
    check("R2 first packet", d_crd, 8'h55);
    op(OP_CRD, 8'h00);
    check("R2 second packet waits", d_rdy, 1);
    check("R2 second packet data", d_crd, 8'h66);
    check("R2 single drops second", s_rdy, 0);
    check("R6 recv busy end", d_busy, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule